// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block owns the read pointer of a synchronous FIFO. It lets the consumer rewind that pointer to the first memory location and read data again that it has already read. A retransmit request is a low level on the active-low retransmit input, seen at a rising read-clock edge after a high level at the previous edge. Before the block accepts a request, it checks two things. The first is the enable state at that edge: a normal-latency request needs both enables idle, while a zero-latency request needs only the write enable idle. The second is that the write count and the read count, each counted since the last reset, lie inside a legal window.

An accepted request starts a setup phase. This phase lasts a fixed number of read-clock cycles. In normal-latency mode the active-low empty output is held low for the whole phase, and its return high shows that reads may resume from location zero. The pointer does not move during setup, and any further request in that phase is dropped. A rejected request raises a one-cycle error pulse and leaves the pointer where it was. When no setup is running, each read-clock edge with read enable low moves the pointer on by one. Master reset and partial reset both return the block to its idle state.

Top module: `rtx_top`

## Requirements
- R1: Master reset or partial reset (both active low and asynchronous) sets rdPtr to 0, emptyN to 1 and setupErr to 0.
- R2: A request is rtN low at a rising edge after rtN was high at the previous edge. Holding rtN low for further edges raises no further request.
- R3: A request is legal only when wrCount and rdCount both lie in the range 2 to DEPTH-1 inclusive (DEPTH=16 by default, so 2..15).
- R4: In normal-latency mode (zeroLat=0), a request needs renN=1 and wenN=1 at the request edge. In zero-latency mode (zeroLat=1) it needs only wenN=1, and the value of renN does not matter.
- R5: After the edge of a legal request, rdPtr is 0.
- R6: After a legal request in normal-latency mode, emptyN is 0 for exactly SETUP_CYC (default 2) cycles starting right after the request edge, then returns to 1. In zero-latency mode emptyN stays 1.
- R7: On a request edge and during setup, renN low does not move rdPtr. A request during setup is dropped and raises no error.
- R8: An illegal request sets setupErr to 1 for exactly one cycle after its edge and leaves rdPtr unchanged.
- R9: Outside setup and outside request edges, an edge with renN low advances rdPtr by one, wrapping from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, asynchronous |
| prstN | input | 1 | Partial reset, active low, asynchronous |
| rtN | input | 1 | Retransmit request, active low |
| renN | input | 1 | Read enable, active low |
| wenN | input | 1 | Write enable, active low |
| zeroLat | input | 1 | 1 = zero-latency mode, 0 = normal-latency mode |
| wrCount | input | CNT_W | Words written since the last reset |
| rdCount | input | CNT_W | Words read since the last reset |
| rdPtr | output | PTR_W | Read pointer |
| emptyN | output | 1 | Empty flag, active low; low during normal-latency setup |
| setupErr | output | 1 | One-cycle pulse on an illegal request |

## Verification
Two functions can fall in the same cycle. A read (renN low) and a retransmit request can share one edge, and a fresh request can arrive while a setup is still running. The bench drives each request edge with every combination of renN and wenN, in both modes, across a full sweep of write counts and several read counts. It then judges the pointer, the error pulse and the empty flag against an arithmetic model: the rewind must win over the read, the pointer must stay fixed during setup, and a second request made inside the setup window must leave no trace.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef struct packed {
    logic rewind;
    logic advance;
  } rtxCtl_t;
endpackage

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
  import rtx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 2,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             rtN,
  input  logic             renN,
  input  logic             wenN,
  input  logic             zeroLat,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  output rtxCtl_t          ctl,
  output logic             emptyN,
  output logic             setupErr
);
  localparam int SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH - 1);
  localparam logic [SC_W-1:0]  LAST_CNT = SC_W'(SETUP_CYC - 1);

  logic rtPrev, busy, modeZl;
  logic [SC_W-1:0] cnt;
  logic request, winOk, enOk, valid, bad;
  logic rstAny;

  assign rstAny = !mrstN || !prstN;

  always_comb begin
    request = !rtN && rtPrev && !busy;
    winOk = (wrCount >= MIN_CNT) && (wrCount <= MAX_CNT) &&
            (rdCount >= MIN_CNT) && (rdCount <= MAX_CNT);
    enOk = wenN && (zeroLat || renN);
    valid = request && winOk && enOk;
    bad = request && !(winOk && enOk);
    ctl.rewind = valid;
    ctl.advance = !busy && !renN && !request;
  end

  always_ff @(posedge clk or negedge mrstN or negedge prstN) begin
    if (!mrstN || !prstN) begin
      rtPrev   <= 1'b1;
      busy     <= 1'b0;
      modeZl   <= 1'b0;
      cnt      <= '0;
      setupErr <= 1'b0;
    end else begin
      rtPrev   <= rtN;
      setupErr <= bad;
      if (valid) begin
        busy   <= 1'b1;
        modeZl <= zeroLat;
        cnt    <= LAST_CNT;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end
  end

  assign emptyN = !(busy && !modeZl);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rstAny)
    setupErr |=> !setupErr);

  // R6
  empty_fall_chk: assert property (@(posedge clk) disable iff (rstAny)
    $fell(emptyN) |-> ($past(!rtN) && !setupErr));

  // R2
  hold_no_retrig_chk: assert property (@(posedge clk) disable iff (rstAny)
    (!rtN && !rtPrev) |-> (!ctl.rewind && !bad));

  // R7
  busy_no_err_chk: assert property (@(posedge clk) disable iff (rstAny)
    busy |=> !setupErr);
endmodule

// File: rtl/rtx_dpath.sv
module rtx_dpath
  import rtx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  rtxCtl_t          ctl,
  output logic [PTR_W-1:0] rdPtr
);
  localparam logic [PTR_W-1:0] LAST_LOC = PTR_W'(DEPTH - 1);

  logic rstAny;
  assign rstAny = !mrstN || !prstN;

  always_ff @(posedge clk or negedge mrstN or negedge prstN) begin
    if (!mrstN || !prstN) begin
      rdPtr <= '0;
    end else if (ctl.rewind) begin
      rdPtr <= '0;
    end else if (ctl.advance) begin
      rdPtr <= (rdPtr == LAST_LOC) ? '0 : rdPtr + 1'b1;
    end
  end

  // R5
  rewind_zero_chk: assert property (@(posedge clk) disable iff (rstAny)
    ctl.rewind |=> (rdPtr == '0));

  // R7
  hold_ptr_chk: assert property (@(posedge clk) disable iff (rstAny)
    (!ctl.rewind && !ctl.advance) |=> $stable(rdPtr));

  // R9
  step_chk: assert property (@(posedge clk) disable iff (rstAny)
    (ctl.advance && !ctl.rewind) |=>
      (rdPtr == (($past(rdPtr) == LAST_LOC) ? '0 : $past(rdPtr) + 1'b1)));

  // R7
  rewind_wins_chk: assert property (@(posedge clk) disable iff (rstAny)
    ctl.rewind |-> !ctl.advance);
endmodule

// File: rtl/rtx_top.sv
module rtx_top
  import rtx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 2,
  parameter int CNT_W     = $clog2(DEPTH) + 2,
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             rtN,
  input  logic             renN,
  input  logic             wenN,
  input  logic             zeroLat,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [CNT_W-1:0] rdCount,
  output logic [PTR_W-1:0] rdPtr,
  output logic             emptyN,
  output logic             setupErr
);
  rtxCtl_t ctl;

  rtx_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .rtN(rtN), .renN(renN),
    .wenN(wenN), .zeroLat(zeroLat), .wrCount(wrCount), .rdCount(rdCount),
    .ctl(ctl), .emptyN(emptyN), .setupErr(setupErr)
  );

  rtx_dpath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) dpath_i (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .ctl(ctl), .rdPtr(rdPtr)
  );
endmodule

// File: tb/rtx_top_tb_top.sv
module rtx_top_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = 6;
  localparam int PTR_W = 4;

  logic clk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, rtN = 1'b1, renN = 1'b1, wenN = 1'b1, zeroLat = 1'b0;
  logic [CNT_W-1:0] wrCount = '0, rdCount = '0;
  logic [PTR_W-1:0] rdPtr;
  logic emptyN, setupErr;

  int errors = 0, total = 0, expPtr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rtx_top dut_i (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .rtN(rtN), .renN(renN),
    .wenN(wenN), .zeroLat(zeroLat), .wrCount(wrCount), .rdCount(rdCount),
    .rdPtr(rdPtr), .emptyN(emptyN), .setupErr(setupErr)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic rt, logic ren);
    @(negedge clk);
    rtN = rt;
    renN = ren;
  endtask

  task automatic trial(int wc, int rc, int zl, int ren, int wen);
    bit ok;
    ok = (wc >= 2) && (wc <= DEPTH - 1) && (rc >= 2) && (rc <= DEPTH - 1) &&
         (wen == 1) && (zl == 1 || ren == 1);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0);
      tick();
      expPtr = (expPtr + 1) % DEPTH;
    end
    chk("R9 advance", rdPtr, expPtr);
    @(negedge clk);
    rtN = 1'b0; renN = ren[0]; wenN = wen[0]; zeroLat = zl[0];
    wrCount = CNT_W'(wc); rdCount = CNT_W'(rc);
    tick();
    if (ok) expPtr = 0;
    chk(ok ? "R5 rewind" : "R8 ptr kept", rdPtr, expPtr);
    chk("R3 R4 R8 err", setupErr, ok ? 0 : 1);
    chk("R6 empty first", emptyN, (ok && zl == 0) ? 0 : 1);
    drive(1'b0, 1'b0);
    wenN = 1'b1;
    tick();
    if (!ok) expPtr = (expPtr + 1) % DEPTH;
    chk("R2 R7 held rt", rdPtr, expPtr);
    chk("R2 R8 no retrigger err", setupErr, 0);
    chk("R6 empty second", emptyN, (ok && zl == 0) ? 0 : 1);
    drive(1'b1, 1'b0);
    tick();
    if (!ok) expPtr = (expPtr + 1) % DEPTH;
    chk("R7 no advance in setup", rdPtr, expPtr);
    chk("R6 empty released", emptyN, 1);
    tick();
    expPtr = (expPtr + 1) % DEPTH;
    chk("R9 read after setup", rdPtr, expPtr);
    drive(1'b1, 1'b1);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    chk("R1 reset ptr", rdPtr, 0);
    chk("R1 reset empty", emptyN, 1);
    chk("R1 reset err", setupErr, 0);
    @(negedge clk);
    mrstN = 1'b1;
    tick();

    // R9 wrap across DEPTH
    for (int i = 0; i < DEPTH + 2; i++) begin
      drive(1'b1, 1'b0);
      tick();
      expPtr = (expPtr + 1) % DEPTH;
    end
    chk("R9 wrap", rdPtr, expPtr);

    // R1 partial reset
    @(negedge clk);
    prstN = 1'b0;
    #1;
    chk("R1 partial reset ptr", rdPtr, 0);
    @(negedge clk);
    prstN = 1'b1;
    renN = 1'b1;
    expPtr = 0;

    for (int wc = 0; wc <= DEPTH + 1; wc++)
      for (int ri = 0; ri < 5; ri++)
        for (int zl = 0; zl < 2; zl++)
          for (int ren = 0; ren < 2; ren++)
            for (int wen = 0; wen < 2; wen++) begin
              int rc;
              rc = (ri == 0) ? 1 : (ri == 1) ? 2 : (ri == 2) ? 9 : (ri == 3) ? DEPTH - 1 : DEPTH;
              trial(wc, rc, zl, ren, wen);
            end

    // R7 request inside setup window is dropped
    @(negedge clk);
    rtN = 1'b0; renN = 1'b1; wenN = 1'b1; zeroLat = 1'b0;
    wrCount = CNT_W'(5); rdCount = CNT_W'(5);
    tick();
    expPtr = 0;
    chk("R5 rewind before second", rdPtr, 0);
    drive(1'b1, 1'b1);
    tick();
    drive(1'b0, 1'b0);
    wrCount = '0;
    tick();
    chk("R7 dropped request err", setupErr, 0);
    chk("R7 dropped request ptr", rdPtr, 0);
    chk("R7 dropped request empty", emptyN, 1);
    drive(1'b1, 1'b1);
    tick();
    chk("R7 no late err", setupErr, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule